// File: doc/BRIEF.md
# Receive Hash Queue Steering

This block picks a receive queue for each arriving packet. A parser ahead of it supplies the EtherType, the IP protocol number, the IPv4 source and destination addresses and the two L4 port numbers, together with a one-cycle valid strobe. The block chooses which of those fields feed a keyed Toeplitz hash and computes the 32-bit hash against a 40-byte programmable key. It then uses the hash to index a programmable indirection table, which yields a 6-bit queue number.

The hash is built one input byte per cycle. Hash and queue appear together with a one-cycle done pulse a fixed 13 cycles after the packet is accepted. Key and table contents are loaded through two plain write ports. A table-size control selects a 128-entry or a 512-entry table, and is captured when the packet is accepted.

Top module: `rxq_hash_steer`

## Requirements
- R1: An IPv4 packet (EtherType 0x0800) with protocol 6 is hashed over 96 bits: source address, destination address, source port, destination port, each most significant byte first. Input bit i (i = 0 for the MSB) set means the result is XORed with key bits i to i+31. Key bit 0 is the MSB of key byte 0.
- R2: An IPv4 packet with protocol 17 is hashed over the same 96-bit layout, using its ports.
- R3: An IPv4 packet with any other protocol is hashed over both addresses with both port fields taken as zero, whatever the port inputs carry.
- R4: A packet whose EtherType is not 0x0800 reports hash 0 and queue 0.
- R5: With the table-size input low at acceptance, the table index is hash mod 128. With it high, the index is hash mod 512.
- R6: Table word w (write index w) holds entries 4w to 4w+3. Entry e sits in bits 8*(e mod 4)+7 down to 8*(e mod 4) of word e/4. The queue is the low 6 bits of that byte.
- R7: A packet is accepted on a clock edge where valid is high and no packet is in flight. Done is high for exactly one cycle, following the 13th edge after acceptance. Hash and queue change only at that edge and hold until the next result.
- R8: Valid asserted from the acceptance edge up to and including the result edge is ignored, and produces no extra result.
- R9: Key word k (k = 0 to 9) holds key bytes 4k to 4k+3, with byte 4k in bits 31:24. A key write lands on the edge it is presented. A packet uses the key as it stood at its acceptance edge, so writes during a computation affect only later packets. Key write indexes 10 to 15 change nothing.
- R10: Synchronous active-high reset clears done, hash, queue, the whole key and the whole table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid_i | input | 1 | Header fields valid |
| ethertype_i | input | 16 | EtherType |
| ip_proto_i | input | 8 | IP protocol number |
| src_ip_i | input | 32 | IPv4 source address |
| dst_ip_i | input | 32 | IPv4 destination address |
| src_port_i | input | 16 | L4 source port |
| dst_port_i | input | 16 | L4 destination port |
| big_table_i | input | 1 | 0: 128-entry table, 1: 512-entry table |
| key_wr_en_i | input | 1 | Key word write strobe |
| key_wr_idx_i | input | 4 | Key word index |
| key_wr_data_i | input | 32 | Key word data |
| tbl_wr_en_i | input | 1 | Table word write strobe |
| tbl_wr_idx_i | input | 7 | Table word index |
| tbl_wr_data_i | input | 32 | Table word data, four entries |
| done_o | output | 1 | One-cycle result strobe |
| hash_o | output | 32 | Toeplitz hash |
| queue_o | output | 6 | Selected queue |

## Verification
The bench sends non-TCP/UDP IPv4 packets with nonzero port inputs. A design that fed the ports into the hash would produce a hash that differs from the address-only value. It fills every table byte with its top two bits set and switches between the 128- and 512-entry sizes. A wrong mask would show up as an out-of-range queue, and a wrong modulus or lane pick as a wrong queue. It rewrites the key mid-computation and raises valid during the busy window, including on the result edge. A design without a key snapshot would change the in-flight hash, and one that accepted early would emit extra or shifted done pulses. Non-IPv4 EtherTypes must yield zero hash and queue 0 even with a populated table.

// File: rtl/rxq_steer_pkg.sv
package rxq_steer_pkg;

    localparam int TUPLE_BYTES = 12;
    localparam int KEY_BYTES   = 40;
    localparam int HASH_W      = 32;
    localparam int TUPLE_W     = TUPLE_BYTES * 8;
    localparam int KEY_W       = KEY_BYTES * 8;
    localparam int WIN_W       = HASH_W + 7;

    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [7:0]  PROTO_TCP  = 8'd6;
    localparam logic [7:0]  PROTO_UDP  = 8'd17;

    typedef enum logic [1:0] {
        CLS_TCP4    = 2'd0,
        CLS_UDP4    = 2'd1,
        CLS_L3_ONLY = 2'd2,
        CLS_NON_IP  = 2'd3
    } pkt_class_e;

    typedef struct packed {
        logic [31:0] src_addr;
        logic [31:0] dst_addr;
        logic [15:0] src_l4;
        logic [15:0] dst_l4;
    } flow_key_t;

    function automatic pkt_class_e classify(input logic [15:0] etype,
                                            input logic [7:0]  proto);
        pkt_class_e c;
        if (etype != ETYPE_IPV4)      c = CLS_NON_IP;
        else if (proto == PROTO_TCP)  c = CLS_TCP4;
        else if (proto == PROTO_UDP)  c = CLS_UDP4;
        else                          c = CLS_L3_ONLY;
        return c;
    endfunction

    // Selects which header fields reach the hash for a given class.
    function automatic flow_key_t hash_input(input pkt_class_e cls,
                                             input flow_key_t  raw);
        flow_key_t f;
        f = raw;
        case (cls)
            CLS_L3_ONLY: begin
                f.src_l4 = '0;
                f.dst_l4 = '0;
            end
            CLS_NON_IP:  f = '0;
            default:     f = raw;
        endcase
        return f;
    endfunction

    // XOR contribution of one input byte against a 39-bit key window.
    function automatic logic [HASH_W-1:0] byte_contrib(input logic [7:0]       b,
                                                       input logic [WIN_W-1:0] win);
        logic [HASH_W-1:0] r;
        r = '0;
        for (int j = 0; j < 8; j++) begin
            if (b[7-j]) r = r ^ win[WIN_W-1-j -: HASH_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/rxq_key_store.sv
module rxq_key_store
    import rxq_steer_pkg::*;
#(
    parameter int K_BYTES = KEY_BYTES
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en_i,
    input  logic [$clog2(K_BYTES/4)-1:0]      wr_idx_i,
    input  logic [31:0]                       wr_data_i,
    output logic [K_BYTES*8-1:0]              key_o
);
    localparam int K_W   = K_BYTES * 8;
    localparam int WORDS = K_BYTES / 4;
    localparam int IDX_W = $clog2(WORDS);

    logic [31:0] words_q [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) words_q[w] <= '0;
        end else if (wr_en_i) begin
            for (int w = 0; w < WORDS; w++) begin
                if (wr_idx_i == IDX_W'(w)) words_q[w] <= wr_data_i;
            end
        end
    end

    // Word 0 forms the most significant end of the key vector.
    always_comb begin
        key_o = '0;
        for (int w = 0; w < WORDS; w++) begin
            key_o[K_W-1-32*w -: 32] = words_q[w];
        end
    end

endmodule

// File: rtl/rxq_toeplitz_engine.sv
module rxq_toeplitz_engine
    import rxq_steer_pkg::*;
#(
    parameter int IN_BYTES = TUPLE_BYTES,
    parameter int K_BYTES  = KEY_BYTES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [IN_BYTES*8-1:0]  tuple_i,
    input  logic [K_BYTES*8-1:0]   key_i,
    output logic                   busy_o,
    output logic                   finish_o,
    output logic [HASH_W-1:0]      hash_o
);
    localparam int IN_W  = IN_BYTES * 8;
    localparam int K_W   = K_BYTES * 8;
    localparam int CNT_W = $clog2(IN_BYTES);
    localparam int LAST  = IN_BYTES - 1;

    logic [IN_W-1:0]   in_sh;
    logic [K_W-1:0]    key_sh;
    logic [HASH_W-1:0] acc;
    logic [CNT_W-1:0]  cnt;
    logic              busy_q;
    logic              fin_q;
    logic [HASH_W-1:0] contrib;

    assign contrib = byte_contrib(in_sh[IN_W-1 -: 8], key_sh[K_W-1 -: WIN_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_sh  <= '0;
            key_sh <= '0;
            acc    <= '0;
            cnt    <= '0;
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (busy_q) begin
                acc    <= acc ^ contrib;
                in_sh  <= in_sh << 8;
                key_sh <= key_sh << 8;
                cnt    <= cnt + 1'b1;
                if (cnt == CNT_W'(LAST)) begin
                    busy_q <= 1'b0;
                    fin_q  <= 1'b1;
                end
            end else if (start_i) begin
                // Key is captured here; later key writes do not reach this packet.
                in_sh  <= tuple_i;
                key_sh <= key_i;
                acc    <= '0;
                cnt    <= '0;
                busy_q <= 1'b1;
            end
        end
    end

    assign busy_o   = busy_q;
    assign finish_o = fin_q;
    assign hash_o   = acc;

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !busy_q); // R8

    AST_FINISH_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        fin_q |-> !busy_q); // R7

endmodule

// File: rtl/rxq_indir_table.sv
module rxq_indir_table
    import rxq_steer_pkg::*;
#(
    parameter int ENTRIES_MAX = 512,
    parameter int ENTRIES_MIN = 128,
    parameter int Q_W         = 6
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en_i,
    input  logic [$clog2(ENTRIES_MAX/4)-1:0]   wr_idx_i,
    input  logic [31:0]                        wr_data_i,
    input  logic                               rd_en_i,
    input  logic                               rd_large_i,
    input  logic [$clog2(ENTRIES_MAX)-1:0]     rd_idx_i,
    output logic [Q_W-1:0]                     rd_queue_o
);
    localparam int WORDS   = ENTRIES_MAX / 4;
    localparam int E_IDX_W = $clog2(ENTRIES_MAX);

    logic [31:0] mem_q [WORDS];
    logic [31:0] sel_word;
    logic [7:0]  sel_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
        end else if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_data_i;
        end
    end

    // Four entries per word; the two low index bits pick the byte lane.
    assign sel_word   = mem_q[rd_idx_i[E_IDX_W-1:2]];
    assign sel_byte   = sel_word[8*rd_idx_i[1:0] +: 8];
    assign rd_queue_o = sel_byte[Q_W-1:0];

    AST_SMALL_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && !rd_large_i) |-> (rd_idx_i < E_IDX_W'(ENTRIES_MIN))); // R5

endmodule

// File: rtl/rxq_hash_steer.sv
module rxq_hash_steer
    import rxq_steer_pkg::*;
#(
    parameter int SMALL_ENTRIES = 128,
    parameter int LARGE_ENTRIES = 512,
    parameter int QUEUE_W       = 6,
    parameter int KEY_LEN       = KEY_BYTES
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 pkt_valid_i,
    input  logic [15:0]                          ethertype_i,
    input  logic [7:0]                           ip_proto_i,
    input  logic [31:0]                          src_ip_i,
    input  logic [31:0]                          dst_ip_i,
    input  logic [15:0]                          src_port_i,
    input  logic [15:0]                          dst_port_i,
    input  logic                                 big_table_i,
    input  logic                                 key_wr_en_i,
    input  logic [$clog2(KEY_LEN/4)-1:0]         key_wr_idx_i,
    input  logic [31:0]                          key_wr_data_i,
    input  logic                                 tbl_wr_en_i,
    input  logic [$clog2(LARGE_ENTRIES/4)-1:0]   tbl_wr_idx_i,
    input  logic [31:0]                          tbl_wr_data_i,
    output logic                                 done_o,
    output logic [HASH_W-1:0]                    hash_o,
    output logic [QUEUE_W-1:0]                   queue_o
);
    localparam int ENT_IDX_W   = $clog2(LARGE_ENTRIES);
    localparam int SMALL_IDX_W = $clog2(SMALL_ENTRIES);
    localparam int LATENCY     = TUPLE_BYTES + 1;
    localparam int LAT_W       = $clog2(LATENCY + 1);

    flow_key_t  raw_flow;
    flow_key_t  hin_flow;
    pkt_class_e in_cls;
    logic       start;

    logic [KEY_LEN*8-1:0] key_vec;
    logic                 eng_busy;
    logic                 eng_fin;
    logic [HASH_W-1:0]    eng_hash;

    logic [ENT_IDX_W-1:0] rd_idx;
    logic [QUEUE_W-1:0]   tbl_queue;

    logic                 active_q;
    pkt_class_e           cls_q;
    logic                 large_q;
    logic                 done_q;
    logic [HASH_W-1:0]    hash_q;
    logic [QUEUE_W-1:0]   queue_q;
    logic [LAT_W-1:0]     lat_q;

    always_comb begin
        raw_flow.src_addr = src_ip_i;
        raw_flow.dst_addr = dst_ip_i;
        raw_flow.src_l4   = src_port_i;
        raw_flow.dst_l4   = dst_port_i;
    end

    assign in_cls   = classify(ethertype_i, ip_proto_i);
    assign hin_flow = hash_input(in_cls, raw_flow);
    assign start    = pkt_valid_i && !active_q;

    rxq_key_store #(
        .K_BYTES (KEY_LEN)
    ) u_key (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (key_wr_en_i),
        .wr_idx_i  (key_wr_idx_i),
        .wr_data_i (key_wr_data_i),
        .key_o     (key_vec)
    );

    rxq_toeplitz_engine #(
        .IN_BYTES (TUPLE_BYTES),
        .K_BYTES  (KEY_LEN)
    ) u_eng (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .tuple_i  (hin_flow),
        .key_i    (key_vec),
        .busy_o   (eng_busy),
        .finish_o (eng_fin),
        .hash_o   (eng_hash)
    );

    // Power-of-two table sizes: the modulo is a mask of the low hash bits.
    assign rd_idx = large_q ? eng_hash[ENT_IDX_W-1:0]
                            : ENT_IDX_W'(eng_hash[SMALL_IDX_W-1:0]);

    rxq_indir_table #(
        .ENTRIES_MAX (LARGE_ENTRIES),
        .ENTRIES_MIN (SMALL_ENTRIES),
        .Q_W         (QUEUE_W)
    ) u_tbl (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (tbl_wr_en_i),
        .wr_idx_i   (tbl_wr_idx_i),
        .wr_data_i  (tbl_wr_data_i),
        .rd_en_i    (eng_fin),
        .rd_large_i (large_q),
        .rd_idx_i   (rd_idx),
        .rd_queue_o (tbl_queue)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cls_q    <= CLS_NON_IP;
            large_q  <= 1'b0;
            done_q   <= 1'b0;
            hash_q   <= '0;
            queue_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                active_q <= 1'b1;
                cls_q    <= in_cls;
                large_q  <= big_table_i;
            end
            if (eng_fin) begin
                active_q <= 1'b0;
                done_q   <= 1'b1;
                if (cls_q == CLS_NON_IP) begin
                    hash_q  <= '0;
                    queue_q <= '0;
                end else begin
                    hash_q  <= eng_hash;
                    queue_q <= tbl_queue;
                end
            end
        end
    end

    // Cycle counter used only by the latency check.
    always_ff @(posedge clk) begin
        if (rst)           lat_q <= '0;
        else if (start)    lat_q <= '0;
        else if (active_q) lat_q <= lat_q + 1'b1;
    end

    assign done_o  = done_q;
    assign hash_o  = hash_q;
    assign queue_o = queue_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R7

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (lat_q == LAT_W'(LATENCY))); // R7

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !eng_fin |=> ($stable(hash_q) && $stable(queue_q))); // R7

    AST_NONIP_ZEROED: assert property (@(posedge clk) disable iff (rst)
        (done_q && cls_q == CLS_NON_IP) |-> (hash_q == '0 && queue_q == '0)); // R4

    AST_ENGINE_TRACKS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        eng_busy |-> active_q); // R8

endmodule

// File: tb/rxq_hash_steer_tb.sv
`timescale 1ns/1ps
module rxq_hash_steer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_valid = 1'b0;
    logic [15:0] etype = '0;
    logic [7:0]  proto = '0;
    logic [31:0] sip = '0, dip = '0;
    logic [15:0] sport = '0, dport = '0;
    logic        big = 1'b0;
    logic        key_en = 1'b0;
    logic [3:0]  key_idx = '0;
    logic [31:0] key_dat = '0;
    logic        tbl_en = 1'b0;
    logic [6:0]  tbl_idx = '0;
    logic [31:0] tbl_dat = '0;
    logic        done_o;
    logic [31:0] hash_o;
    logic [5:0]  queue_o;

    always #2.5 clk = ~clk;

    rxq_hash_steer u_dut (
        .clk(clk), .rst(rst), .pkt_valid_i(pkt_valid), .ethertype_i(etype),
        .ip_proto_i(proto), .src_ip_i(sip), .dst_ip_i(dip), .src_port_i(sport),
        .dst_port_i(dport), .big_table_i(big), .key_wr_en_i(key_en),
        .key_wr_idx_i(key_idx), .key_wr_data_i(key_dat), .tbl_wr_en_i(tbl_en),
        .tbl_wr_idx_i(tbl_idx), .tbl_wr_data_i(tbl_dat), .done_o(done_o),
        .hash_o(hash_o), .queue_o(queue_o)
    );

    int n_chk = 0, n_fail = 0;
    int n_model_done = 0, n_dut_done = 0;
    bit started = 0;
    string cur_tag = "none";

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_key [10];
    logic [31:0] m_tbl [128];
    int          m_busy = 0;
    logic        m_exp_done = 0;
    logic [31:0] m_exp_hash = '0, m_pend = '0;
    logic [5:0]  m_exp_q = '0;
    logic        m_nonip = 0, m_large = 0;
    string       m_tag = "none", m_exp_tag = "none";

    function automatic logic [31:0] toeplitz(input logic [95:0] din, input logic [319:0] k);
        logic [31:0] r = '0;
        for (int i = 0; i < 96; i++)
            if (din[95-i]) r = r ^ k[319-i -: 32];
        return r;
    endfunction

    function automatic logic [5:0] lookup(input logic [31:0] h, input logic lg);
        int idx = lg ? int'(h % 512) : int'(h % 128);
        logic [31:0] wd = m_tbl[idx / 4];
        logic [7:0]  b  = wd[8*(idx % 4) +: 8];
        return b[5:0];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 10; i++) m_key[i] = '0;
            for (int i = 0; i < 128; i++) m_tbl[i] = '0;
            m_busy = 0;
            m_exp_done = 0;
        end else begin
            m_exp_done = 0;
            if (m_busy > 0) begin
                m_busy--;
                if (m_busy == 0) begin
                    m_exp_done = 1;
                    m_exp_hash = m_nonip ? 32'h0 : m_pend;
                    m_exp_q    = m_nonip ? 6'h0 : lookup(m_pend, m_large);
                    m_exp_tag  = m_tag;
                    n_model_done++;
                end
            end else if (pkt_valid) begin
                logic [319:0] kv;
                logic [95:0]  t;
                for (int w = 0; w < 10; w++) kv[319-32*w -: 32] = m_key[w];
                m_nonip = (etype != 16'h0800);
                if (proto == 8'd6 || proto == 8'd17) t = {sip, dip, sport, dport};
                else t = {sip, dip, 32'h0};
                m_pend  = toeplitz(t, kv);
                m_large = big;
                m_tag   = cur_tag;
                m_busy  = 13;
            end
            if (key_en && key_idx < 4'd10) m_key[key_idx] = key_dat;
            if (tbl_en) m_tbl[tbl_idx] = tbl_dat;
        end
    end

    always @(negedge clk) begin
        if (!rst && started) begin
            chk(done_o == m_exp_done, "R7 done timing", {31'h0, done_o}, {31'h0, m_exp_done});
            if (done_o) n_dut_done++;
            if (m_exp_done) begin
                chk(hash_o == m_exp_hash, m_exp_tag, hash_o, m_exp_hash);
                chk(queue_o == m_exp_q, {m_exp_tag, " R5 R6 queue"}, {26'h0, queue_o}, {26'h0, m_exp_q});
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr_key(input int idx, input logic [31:0] d);
        @(negedge clk); key_en = 1; key_idx = 4'(idx); key_dat = d;
        @(negedge clk); key_en = 0;
    endtask

    task automatic wr_tbl(input int idx, input logic [31:0] d);
        @(negedge clk); tbl_en = 1; tbl_idx = 7'(idx); tbl_dat = d;
        @(negedge clk); tbl_en = 0;
    endtask

    task automatic send(input logic [15:0] et, input logic [7:0] pr, input logic [31:0] s,
                        input logic [31:0] d, input logic [15:0] sp, input logic [15:0] dp,
                        input logic lg, input string tag);
        @(negedge clk);
        etype = et; proto = pr; sip = s; dip = d; sport = sp; dport = dp; big = lg;
        cur_tag = tag; pkt_valid = 1;
        @(negedge clk); pkt_valid = 0;
    endtask

    task automatic settle();
        repeat (16) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R7 watchdog expired act=%0d exp=0", 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(done_o == 0, "R10 reset done", {31'h0, done_o}, 0);
        chk(hash_o == 0, "R10 reset hash", hash_o, 0);
        chk(queue_o == 0, "R10 reset queue", {26'h0, queue_o}, 0);
        started = 1;
        send(16'h0800, 8'd6, 32'hC0A80001, 32'h0A000002, 16'd1234, 16'd80, 0, "R10 cleared key");
        settle();

        for (int w = 0; w < 10; w++) wr_key(w, 32'h6d5a56da ^ (32'(w) * 32'h9e3779b9));
        for (int w = 0; w < 128; w++) begin
            logic [31:0] d;
            for (int l = 0; l < 4; l++) begin
                int e = 4*w + l;
                d[8*l +: 8] = {2'b11, 6'(e*13 + 5)};
            end
            wr_tbl(w, d);
        end

        // R1 TCP four-tuple
        send(16'h0800, 8'd6, 32'h42661a3d, 32'ha18e6450, 16'd2794, 16'd1766, 0, "R1 tcp a");
        settle();
        send(16'h0800, 8'd6, 32'h199a0b55, 32'h00ffff01, 16'd14230, 16'd4739, 0, "R1 tcp b");
        settle();
        send(16'h0800, 8'd6, 32'hffffffff, 32'hffffffff, 16'hffff, 16'hffff, 0, "R1 tcp ones");
        settle();
        // R5 large table
        send(16'h0800, 8'd6, 32'h42661a3d, 32'ha18e6450, 16'd2794, 16'd1766, 1, "R5 large tcp");
        settle();
        send(16'h0800, 8'd17, 32'h26f0d4e1, 32'h7b0a9c33, 16'd53, 16'd5353, 1, "R5 large udp");
        settle();
        // R2 UDP
        send(16'h0800, 8'd17, 32'hac100001, 32'hac100002, 16'd4000, 16'd4001, 0, "R2 udp a");
        settle();
        send(16'h0800, 8'd17, 32'h01020304, 32'h05060708, 16'd0, 16'd65535, 0, "R2 udp b");
        settle();
        // R3 other IPv4 protocols, ports must be ignored
        send(16'h0800, 8'd1, 32'hac100001, 32'hac100002, 16'd4000, 16'd4001, 0, "R3 icmp ports zeroed");
        settle();
        send(16'h0800, 8'd47, 32'h0a0a0a0a, 32'h0b0b0b0b, 16'hbeef, 16'hcafe, 1, "R3 gre ports zeroed");
        settle();
        // R4 non-IPv4
        send(16'h86dd, 8'd6, 32'h42661a3d, 32'ha18e6450, 16'd2794, 16'd1766, 1, "R4 ipv6 etype");
        settle();
        send(16'h0806, 8'd17, 32'h11111111, 32'h22222222, 16'd1, 16'd2, 0, "R4 arp etype");
        settle();

        // R8: valid during busy and on the result edge is ignored
        send(16'h0800, 8'd6, 32'h0badf00d, 32'h12345678, 16'd100, 16'd200, 0, "R8 first packet");
        @(negedge clk); etype = 16'h0800; proto = 8'd17; sip = 32'h99999999; pkt_valid = 1;
        repeat (3) @(negedge clk); pkt_valid = 0;
        repeat (8) @(negedge clk); pkt_valid = 1; sip = 32'h77777777;
        @(negedge clk); pkt_valid = 0;
        settle();

        // R9: key writes mid computation affect the next packet only
        send(16'h0800, 8'd6, 32'h42661a3d, 32'ha18e6450, 16'd2794, 16'd1766, 0, "R9 old key in flight");
        @(negedge clk); key_en = 1; key_idx = 4'd0; key_dat = 32'h13572468;
        @(negedge clk); key_idx = 4'd3; key_dat = 32'hfedcba98;
        @(negedge clk); key_en = 0;
        settle();
        send(16'h0800, 8'd6, 32'h42661a3d, 32'ha18e6450, 16'd2794, 16'd1766, 0, "R9 new key");
        settle();
        wr_key(12, 32'hffffffff);
        wr_key(15, 32'hffffffff);
        send(16'h0800, 8'd6, 32'h42661a3d, 32'ha18e6450, 16'd2794, 16'd1766, 0, "R9 out-of-range key write");
        settle();
        // R6 table rewrite with distinct lane values
        wr_tbl(0, 32'h3f2a1500);
        send(16'h0800, 8'd6, 32'h0, 32'h0, 16'd0, 16'd0, 0, "R6 zero tuple lane");
        settle();

        chk(n_dut_done == n_model_done, "R8 result count", 32'(n_dut_done), 32'(n_model_done));
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule